// File: doc/BRIEF.md
# BCD real-time calendar counter

This block keeps wall-clock time in seven packed BCD registers: seconds, minutes, hours (24-hour), day of month, weekday, month and two-digit year. A base-rate pulse on `tick_i` feeds a sub-second prescaler. After `TICKS_PER_SEC` pulses the seconds field advances. Carries then ripple through minutes, hours, day and weekday, month and year. Month lengths and leap years are handled. The century flag toggles when the year wraps.

A host reaches the registers through a single-cycle byte port. A write with `wr_en_i` high lands on the next clock edge. Reads are combinational on `addr_i`. To load a coherent time, the host sets the stop bit in the control register, writes the seven time bytes, then clears the stop bit. The top bit of the seconds byte is a clock-integrity flag. It comes up set after reset and tells software the time is not to be trusted until it has been loaded.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the registers read as follows: control 0x00, seconds 0x80 (integrity flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x06, month 0x01 (century 0), year 0x00.
- R2: The address map is control at 0x0, seconds 0x2, minutes 0x3, hours 0x4, day 0x5, weekday 0x6, month 0x7 and year 0x8. Written values are stored under these masks: seconds and minutes 0x7F, hours and day 0x3F, weekday 0x07, month 0x1F, year 0xFF. Any other address reads 0x00.
- R3: One second elapses per `TICKS_PER_SEC` pulses of `tick_i`. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into day and weekday.
- R4: The weekday advances at each midnight and wraps from 6 to 0, where 0 means Sunday.
- R5: After the last day of its month, the day returns to 01 and the month advances. The last day is 30 for months 4, 6, 9 and 11, and 31 for the other months except February. After month 12 the month returns to 01 and the year advances.
- R6: February ends on day 29 when the BCD year is divisible by 4, and on day 28 otherwise.
- R7: When the year wraps from 99 to 00, bit 7 of the month register (century) inverts. A host write to the month register sets that bit directly.
- R8: While bit 5 of the control register is 1, no time field advances and the sub-second phase is held at zero. After the bit is cleared, the first advance comes after exactly `TICKS_PER_SEC` pulses.
- R9: The integrity flag (bit 7 of seconds) is 1 after reset. It changes only on a write to the seconds register, which copies `wdata_i[7]` into it. Counting never changes it.
- R10: A write to any time register resets the sub-second phase. No field advances in the cycle of that write, even if a pulse arrives in the same cycle, so the next advance comes a full `TICKS_PER_SEC` pulses later.
- R11: Control bits 7 and 3 are test bits. They are stored and read back but have no effect on counting. The other control bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base-rate pulse, one cycle wide, feeding the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |

## Verification
The range checks assume the host loads only legal BCD values for each field. The stop-freeze property assumes the host sets the stop bit before a multi-byte load. The directed and random loads in the bench only ever write valid times, with the day held within the month's length, and each load is wrapped in stop set and clear. Rollovers are reached by biasing random start times toward the ends of their ranges. Month ends, leap Februaries and the 99-to-00 year are hit directly.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned ADR_CTL    = 0;
  localparam int unsigned ADR_SEC    = 2;
  localparam int unsigned ADR_MON    = ADR_SEC + 5;
  localparam int unsigned STOP_BIT   = 5;
  localparam logic [7:0]  CTL_MASK   = 8'hA8;

  // index 0 = seconds ... 6 = year
  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_MASK =
    {8'hFF, 8'h1F, 8'h07, 8'h3F, 8'h3F, 8'h7F, 8'h7F};
  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_LO =
    {8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_RST =
    {8'h00, 8'h01, 8'h06, 8'h01, 8'h00, 8'h00, 8'h00};

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DAY = 3'd3,
    F_WDAY = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
  } field_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + o divisible by 4  <=>  (2t + o) mod 4 == 0
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'b00;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic sec_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign sec_o = tick_i && !hold_i && !clr_i && (cnt_q == CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (hold_i || clr_i)    cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == CNT_TOP)      cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_day_o
);
  import rtc_cal_pkg::*;

  always_comb begin
    unique case (month_i)
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      8'h02:                      last_day_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MASK = 8'h7F,
  parameter logic [7:0] LO   = 8'h00,
  parameter logic [7:0] RST  = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic [7:0] hi_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  import rtc_cal_pkg::*;

  logic [7:0] val_q;

  // >= rather than == so an out-of-range load still wraps
  assign wrap_o = inc_i && (val_q >= hi_i);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST;
    else if (ld_i)   val_q <= ld_val_i & MASK;
    else if (inc_i)  val_q <= wrap_o ? LO : (bcd_inc(val_q) & MASK);
  end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned ADDR_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  import rtc_cal_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADR_CTL);
  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(ADR_SEC);
  localparam logic [ADDR_W-1:0] A_MON = ADDR_W'(ADR_MON);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(ADR_SEC + NUM_FIELDS - 1);

  logic [7:0] ctl_q;
  logic       vl_q, cent_q;
  logic       stop, time_wr, sec_pulse;
  logic [7:0] last_day;
  logic [NUM_FIELDS-1:0][7:0] fval, fhi;
  logic [NUM_FIELDS-1:0]      finc, fwrap, fld;

  assign stop    = ctl_q[STOP_BIT];
  assign time_wr = wr_en_i && (addr_i >= A_SEC) && (addr_i <= A_END);

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (stop),
    .clr_i  (time_wr),
    .sec_o  (sec_pulse)
  );

  rtc_month_len u_mlen (
    .month_i    (fval[F_MON]),
    .year_i     (fval[F_YEAR]),
    .last_day_o (last_day)
  );

  // carry chain; day and weekday share the midnight carry
  assign finc[F_SEC]  = sec_pulse;
  assign finc[F_MIN]  = fwrap[F_SEC];
  assign finc[F_HOUR] = fwrap[F_MIN];
  assign finc[F_DAY]  = fwrap[F_HOUR];
  assign finc[F_WDAY] = fwrap[F_HOUR];
  assign finc[F_MON]  = fwrap[F_DAY];
  assign finc[F_YEAR] = fwrap[F_MON];

  assign fhi[F_SEC]  = 8'h59;
  assign fhi[F_MIN]  = 8'h59;
  assign fhi[F_HOUR] = 8'h23;
  assign fhi[F_DAY]  = last_day;
  assign fhi[F_WDAY] = 8'h06;
  assign fhi[F_MON]  = 8'h12;
  assign fhi[F_YEAR] = 8'h99;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign fld[i] = wr_en_i && (addr_i == ADDR_W'(ADR_SEC + i));
    rtc_bcd_field #(
      .MASK (FIELD_MASK[i]),
      .LO   (FIELD_LO[i]),
      .RST  (FIELD_RST[i])
    ) u_fld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (finc[i]),
      .hi_i     (fhi[i]),
      .ld_i     (fld[i]),
      .ld_val_i (wdata_i),
      .val_o    (fval[i]),
      .wrap_o   (fwrap[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      vl_q   <= 1'b1;
      cent_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_CTL) ctl_q <= wdata_i & CTL_MASK;
      if (fld[F_SEC])                 vl_q  <= wdata_i[7];
      if (fld[F_MON])                 cent_q <= wdata_i[7];
      else if (fwrap[F_YEAR])         cent_q <= ~cent_q;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_CTL) rdata_o = ctl_q;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr_i == ADDR_W'(ADR_SEC + i)) rdata_o = fval[i];
    if (addr_i == A_SEC) rdata_o[7] = vl_q;
    if (addr_i == A_MON) rdata_o[7] = cent_q;
  end
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              stop_i,
  input logic              sec_inc_i,
  input logic              year_wrap_i,
  input logic [7:0]        sec_i,
  input logic [7:0]        min_i,
  input logic              vl_i,
  input logic              cent_i
);
  logic wr_any, wr_sec, wr_min, wr_mon;
  assign wr_any = wr_en_i && addr_i >= ADDR_W'(2) && addr_i <= ADDR_W'(8);
  assign wr_sec = wr_en_i && addr_i == ADDR_W'(2);
  assign wr_min = wr_en_i && addr_i == ADDR_W'(3);
  assign wr_mon = wr_en_i && addr_i == ADDR_W'(7);

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_any) |=> ($stable(sec_i) && $stable(min_i))); // R8

  AST_VL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_i && !wr_sec) |=> vl_i); // R9

  AST_VL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec |=> (vl_i == $past(wdata_i[7]))); // R9

  AST_CENT_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_wrap_i && !wr_mon) |=> (cent_i != $past(cent_i))); // R7

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_inc_i && sec_i == 8'h59) |=> (sec_i == 8'h00)); // R3

  AST_WR_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_min |=> $stable(sec_i)); // R10
endmodule

bind rtc_cal_core rtc_cal_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .stop_i      (stop),
  .sec_inc_i   (sec_pulse),
  .year_wrap_i (fwrap[6]),
  .sec_i       (fval[0]),
  .min_i       (fval[1]),
  .vl_i        (vl_q),
  .cent_i      (cent_q)
);

// File: tb/rtc_cal_core_bench.sv
`timescale 1ns/1ps
module rtc_cal_core_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  // bench model, binary
  int ms, mm, mh, md, mw, mmo, my, mph;
  int mvl, mcent, mctl;

  always #2.5 clk = ~clk;

  rtc_cal_core #(.TICKS_PER_SEC(DIV), .ADDR_W(4)) u_rtc_cal_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int bin(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mlen(input int mo, input int y);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    case (a)
      0: return 8'(mctl);
      2: return 8'(mvl << 7) | bcd(ms);
      3: return bcd(mm);
      4: return bcd(mh);
      5: return bcd(md);
      6: return bcd(mw);
      7: return 8'(mcent << 7) | bcd(mmo);
      8: return bcd(my);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    ms = 0; mm = 0; mh = 0; md = 1; mw = 6; mmo = 1; my = 0;
    mph = 0; mvl = 1; mcent = 0; mctl = 0;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    if (a >= 2 && a <= 8) mph = 0;
    case (a)
      0: begin mctl = int'(d & 8'hA8); if (d[5]) mph = 0; end
      2: begin ms = bin(d & 8'h7F); mvl = int'(d[7]); end
      3: mm = bin(d & 8'h7F);
      4: mh = bin(d & 8'h3F);
      5: md = bin(d & 8'h3F);
      6: mw = bin(d & 8'h07);
      7: begin mmo = bin(d & 8'h1F); mcent = int'(d[7]); end
      8: my = bin(d);
      default: ;
    endcase
  endtask

  task automatic model_advance();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7;
          if (md == mlen(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin my = 0; mcent ^= 1; end
            end
          end else md++;
        end
      end
    end
  endtask

  task automatic model_tick();
    if ((mctl & 32) != 0) begin mph = 0; return; end
    mph++;
    if (mph == DIV) begin mph = 0; model_advance(); end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic wr_tick(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; tick = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    model_write(a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      model_tick();
    end
  endtask

  task automatic rd_chk(input int a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = 4'(a); #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0h got %02h exp %02h", tag, a, rdata, e);
    end
  endtask

  task automatic chk_all(input string tag);
    rd_chk(0, exp_byte(0), tag);
    for (int a = 2; a <= 8; a++) rd_chk(a, exp_byte(a), tag);
  endtask

  task automatic set_time(input int s, input int m, input int h, input int d,
                          input int w, input int mo, input int y, input int c);
    wr(0, 8'h20);
    wr(2, bcd(s)); wr(3, bcd(m)); wr(4, bcd(h)); wr(5, bcd(d));
    wr(6, bcd(w)); wr(7, 8'(c << 7) | bcd(mo)); wr(8, bcd(y));
    wr(0, 8'h00);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk_all("R1");
    rd_chk(2, 8'h80, "R1");
    rd_chk(6, 8'h06, "R1");

    // R2 map, masks, unused addresses
    wr(3, 8'hFF); rd_chk(3, 8'h7F, "R2");
    wr(6, 8'hFD); rd_chk(6, 8'h05, "R2");
    wr(8, 8'h87); rd_chk(8, 8'h87, "R2");
    rd_chk(1, 8'h00, "R2");
    rd_chk(9, 8'h00, "R2");
    rd_chk(15, 8'h00, "R2");

    // R3 seconds and carries
    set_time(57, 59, 23, 10, 2, 5, 21, 0);
    ticks(DIV - 1); rd_chk(2, bcd(57), "R3");
    ticks(1);       rd_chk(2, bcd(58), "R3");
    ticks(2 * DIV); chk_all("R3");
    set_time(59, 59, 22, 10, 2, 5, 21, 0);
    ticks(DIV); chk_all("R3");

    // R4 weekday wrap
    set_time(59, 59, 23, 14, 6, 5, 21, 0);
    ticks(DIV); chk_all("R4"); rd_chk(6, 8'h00, "R4");

    // R5 month lengths and year advance
    set_time(59, 59, 23, 30, 1, 4, 21, 0);
    ticks(DIV); chk_all("R5"); rd_chk(7, 8'h05, "R5");
    set_time(59, 59, 23, 30, 1, 1, 21, 0);
    ticks(DIV); rd_chk(5, 8'h31, "R5");
    set_time(59, 59, 23, 31, 4, 12, 21, 0);
    ticks(DIV); chk_all("R5"); rd_chk(8, 8'h22, "R5");

    // R6 leap handling
    set_time(59, 59, 23, 28, 3, 2, 24, 0);
    ticks(DIV); rd_chk(5, 8'h29, "R6"); rd_chk(7, 8'h02, "R6");
    ticks(DIV * 60 * 60 * 24 / 24 / 60);
    set_time(59, 59, 23, 29, 4, 2, 24, 0);
    ticks(DIV); rd_chk(5, 8'h01, "R6"); rd_chk(7, 8'h03, "R6");
    set_time(59, 59, 23, 28, 2, 2, 23, 0);
    ticks(DIV); rd_chk(5, 8'h01, "R6"); rd_chk(7, 8'h03, "R6");
    set_time(59, 59, 23, 28, 2, 2, 10, 0);
    ticks(DIV); rd_chk(5, 8'h01, "R6");
    set_time(59, 59, 23, 28, 2, 2, 12, 0);
    ticks(DIV); rd_chk(5, 8'h29, "R6");

    // R7 century flips both ways
    set_time(59, 59, 23, 31, 5, 12, 99, 0);
    ticks(DIV); chk_all("R7"); rd_chk(7, 8'h81, "R7");
    set_time(59, 59, 23, 31, 5, 12, 99, 1);
    ticks(DIV); rd_chk(7, 8'h01, "R7"); rd_chk(8, 8'h00, "R7");

    // R8 stop freezes counting and phase
    set_time(10, 20, 5, 3, 1, 6, 30, 0);
    ticks(DIV - 1);
    wr(0, 8'h20);
    ticks(5 * DIV); chk_all("R8");
    wr(0, 8'h00);
    ticks(DIV - 1); rd_chk(2, bcd(10), "R8");
    ticks(1);       rd_chk(2, bcd(11), "R8");

    // R9 integrity flag
    rst_n = 1'b0; model_reset(); @(negedge clk); rst_n = 1'b1;
    wr(3, 8'h12); ticks(3 * DIV); rd_chk(2, 8'h83, "R9");
    wr(2, 8'h85); rd_chk(2, 8'h85, "R9");
    wr(2, 8'h05); rd_chk(2, 8'h05, "R9");
    ticks(70 * DIV); chk_all("R9");
    wr(2, 8'hC0); rd_chk(2, 8'hC0, "R9");
    wr(2, 8'h00);

    // R10 write resets phase, write beats a same-cycle pulse
    ticks(DIV - 1);
    wr(3, 8'h30);
    ticks(DIV - 1); rd_chk(2, 8'h00, "R10");
    ticks(1);       rd_chk(2, 8'h01, "R10");
    ticks(DIV - 1);
    wr_tick(4, 8'h07); rd_chk(2, 8'h01, "R10");
    ticks(DIV - 1);    rd_chk(2, 8'h01, "R10");
    ticks(1);          chk_all("R10");

    // R11 test bits stored, counting unaffected
    wr(0, 8'hFF); rd_chk(0, 8'hA8, "R11");
    wr(0, 8'h88); rd_chk(0, 8'h88, "R11");
    ticks(3 * DIV); chk_all("R11");
    wr(0, 8'h00);

    // random loads, biased toward rollovers
    for (int it = 0; it < 60; it++) begin
      int s, m, h, d, w, mo, y, c, n;
      logic bias;
      bias = 1'($urandom_range(0, 1));
      mo = $urandom_range(1, 12);
      y  = $urandom_range(0, 99);
      c  = $urandom_range(0, 1);
      w  = $urandom_range(0, 6);
      s  = bias ? $urandom_range(55, 59) : $urandom_range(0, 59);
      m  = bias ? 59 : $urandom_range(0, 59);
      h  = bias ? 23 : $urandom_range(0, 23);
      d  = bias ? mlen(mo, y) : $urandom_range(1, mlen(mo, y));
      if (bias && $urandom_range(0, 3) == 0) begin mo = 12; y = 99; d = 31; end
      set_time(s, m, h, d, w, mo, y, c);
      n = $urandom_range(0, 12 * DIV);
      ticks(n);
      chk_all("R3 R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule